// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio and emits one single-cycle pulse per divided period, for use as the feedback input of a phase detector. It uses a dual-modulus prescaler together with two 6-bit down-counters. The swallow counter holds A. The programmable counter holds B. In each output period the prescaler first runs at P+1 for A of its own cycles and then at P for the remaining B−A cycles. The period is therefore P·B + A input cycles. A select bit sets P to 32 or to 64.

Software writes a new setting by presenting A, B and the select bit with a one-cycle load strobe. The block checks each setting before accepting it. A setting with B below 3 or with B below A is refused, and an error flag is raised. An accepted setting is held back until the current output period ends. Both counters and the prescaler modulus then switch together, so no period is ever cut short or stretched.

Top module: `swallow_divider`

## Requirements
- R1: While reset is high, and in the cycle after it, the pulse output and the error flag are 0. After reset the divider runs with A=0, B=3 and P=32, so the first pulse comes 96 cycles after reset is released.
- R2: When the select bit is 0 (P=32), consecutive pulses are exactly 32·B + A input cycles apart.
- R3: When the select bit is 1 (P=64), consecutive pulses are exactly 64·B + A input cycles apart.
- R4: Each output pulse is high for exactly one input-clock cycle.
- R5: The boundary settings A=0, A=B, and B=A=63 give the exact period from R2 or R3.
- R6: A load with B less than 3 is refused. The error flag reads 1 in the cycle after the load, and the pulse spacing stays at the previous setting.
- R7: A load with B less than A is refused in the same way as R6.
- R8: A legal load clears the error flag in the cycle after the load. Without a load, the error flag does not change.
- R9: An accepted setting takes effect only at the next output-period boundary. The period in progress when the load occurs keeps the old length.
- R10: Within each output period the prescaler completes exactly B cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_a | input | 6 | Swallow count A (0 to 63) |
| cfg_b | input | 6 | Programmable count B (3 to 63, at least A) |
| cfg_hi | input | 1 | Prescaler select: 0 for 32/33, 1 for 64/65 |
| cfg_load | input | 1 | One-cycle strobe that presents a new setting |
| div_pulse | output | 1 | Registered one-cycle pulse, once per divided period |
| cfg_err | output | 1 | Set when the most recent load was refused |

## Verification
If the swallow counter holds a wrong value, every affected period is off by a few cycles. The next pulse interval shows this, so it is visible within one period. A wrong B count or a wrong modulus shifts the interval by a multiple of 32 or 64. If a setting is applied mid-period, the interval straddling the load is wrong. If a setting is accepted when it should be refused, both the error flag and the following intervals are wrong. Measuring two consecutive intervals around every load therefore exposes each of these faults within two periods.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // prescaler modulus choice
  typedef enum logic {
    PRESC_LO = 1'b0,
    PRESC_HI = 1'b1
  } presc_sel_e;
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
#(
  parameter int P_LO = 32,
  parameter int P_HI = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  presc_sel_e sel,
  input  logic       swallow,
  output logic       tick
);
  localparam int PC_W = $clog2(P_HI + 1);

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] last;

  // modulus is base (P) or base+1 while swallowing; last = modulus-1
  always_comb begin
    base = (sel == PRESC_HI) ? PC_W'(P_HI) : PC_W'(P_LO);
    last = base + PC_W'(swallow) - PC_W'(1);
    tick = (pcnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) pcnt <= '0;
    else if (tick) pcnt <= '0;
    else pcnt <= pcnt + PC_W'(1);
  end
endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters #(
  parameter int CNT_W = 6,
  parameter int DEF_A = 0,
  parameter int DEF_B = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] ld_a,
  input  logic [CNT_W-1:0] ld_b,
  output logic             swallow,
  output logic             wrap
);
  logic [CNT_W-1:0] a_rem;
  logic [CNT_W-1:0] b_rem;

  always_comb begin
    swallow = (a_rem != '0);
    wrap    = tick && (b_rem == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem <= CNT_W'(DEF_A);
      b_rem <= CNT_W'(DEF_B);
    end else if (tick) begin
      if (b_rem == CNT_W'(1)) begin
        a_rem <= ld_a;
        b_rem <= ld_b;
      end else begin
        b_rem <= b_rem - CNT_W'(1);
        if (a_rem != '0) a_rem <= a_rem - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
  import swdiv_pkg::*;
#(
  parameter int   CNT_W  = 6,
  parameter int   B_MIN  = 3,
  parameter int   DEF_A  = 0,
  parameter int   DEF_B  = 3,
  parameter bit   DEF_HI = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_a,
  input  logic [CNT_W-1:0] cfg_b,
  input  logic             cfg_hi,
  input  logic             cfg_load,
  input  logic             wrap,
  output logic [CNT_W-1:0] act_a,
  output logic [CNT_W-1:0] act_b,
  output presc_sel_e       act_hi,
  output logic [CNT_W-1:0] nxt_a,
  output logic [CNT_W-1:0] nxt_b,
  output logic             cfg_err
);
  logic [CNT_W-1:0] pend_a;
  logic [CNT_W-1:0] pend_b;
  presc_sel_e       pend_hi;
  presc_sel_e       nxt_hi;
  logic             pend_v;
  logic             legal;

  always_comb begin
    legal  = (cfg_b >= CNT_W'(B_MIN)) && (cfg_b >= cfg_a);
    nxt_a  = pend_v ? pend_a  : act_a;
    nxt_b  = pend_v ? pend_b  : act_b;
    nxt_hi = pend_v ? pend_hi : act_hi;
  end

  // staging register: a fresh legal load wins over a boundary consume
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= 1'b0;
      pend_a  <= '0;
      pend_b  <= '0;
      pend_hi <= PRESC_LO;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_load) cfg_err <= !legal;
      if (cfg_load && legal) begin
        pend_v  <= 1'b1;
        pend_a  <= cfg_a;
        pend_b  <= cfg_b;
        pend_hi <= presc_sel_e'(cfg_hi);
      end else if (wrap) begin
        pend_v <= 1'b0;
      end
    end
  end

  // active setting only moves at the period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      act_a  <= CNT_W'(DEF_A);
      act_b  <= CNT_W'(DEF_B);
      act_hi <= presc_sel_e'(DEF_HI);
    end else if (wrap) begin
      act_a  <= nxt_a;
      act_b  <= nxt_b;
      act_hi <= nxt_hi;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int P_LO   = 32,
  parameter int P_HI   = 64,
  parameter int B_MIN  = 3,
  parameter int DEF_A  = 0,
  parameter int DEF_B  = 3,
  parameter bit DEF_HI = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_a,
  input  logic [CNT_W-1:0] cfg_b,
  input  logic             cfg_hi,
  input  logic             cfg_load,
  output logic             div_pulse,
  output logic             cfg_err
);
  logic [CNT_W-1:0] act_a;
  logic [CNT_W-1:0] act_b;
  presc_sel_e       act_hi;
  logic [CNT_W-1:0] nxt_a;
  logic [CNT_W-1:0] nxt_b;
  logic             pre_tick;
  logic             swallow;
  logic             wrap;

  swdiv_cfg #(
    .CNT_W(CNT_W), .B_MIN(B_MIN), .DEF_A(DEF_A), .DEF_B(DEF_B), .DEF_HI(DEF_HI)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_hi(cfg_hi),
    .cfg_load(cfg_load), .wrap(wrap), .act_a(act_a), .act_b(act_b),
    .act_hi(act_hi), .nxt_a(nxt_a), .nxt_b(nxt_b), .cfg_err(cfg_err)
  );

  swdiv_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk(clk), .rst(rst), .sel(act_hi), .swallow(swallow), .tick(pre_tick)
  );

  swdiv_counters #(.CNT_W(CNT_W), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_cnt (
    .clk(clk), .rst(rst), .tick(pre_tick), .ld_a(nxt_a), .ld_b(nxt_b),
    .swallow(swallow), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else div_pulse <= wrap;
  end
endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
  parameter int CNT_W = 6,
  parameter int B_MIN = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cfg_a,
  input logic [CNT_W-1:0] cfg_b,
  input logic             cfg_load,
  input logic             cfg_err,
  input logic             div_pulse,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] act_a,
  input logic [CNT_W-1:0] act_b,
  input logic             act_hi
);
  logic [CNT_W-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else if (wrap) tcnt <= '0;
    else if (tick) tcnt <= tcnt + CNT_W'(1);
  end

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R6
  short_b_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && cfg_b < CNT_W'(B_MIN)) |=> cfg_err);

  // R7
  b_below_a_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && cfg_b < cfg_a) |=> cfg_err);

  // R8
  legal_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_load && cfg_b >= CNT_W'(B_MIN) && cfg_b >= cfg_a) |=> !cfg_err);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_err));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable({act_a, act_b, act_hi}));

  // R10
  tick_count_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> ((tcnt + CNT_W'(1)) == act_b));

  // R5
  active_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (act_b >= CNT_W'(B_MIN)) && (act_b >= act_a));
endmodule

bind swallow_divider swdiv_chk #(.CNT_W(CNT_W), .B_MIN(B_MIN)) u_chk (
  .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_load(cfg_load),
  .cfg_err(cfg_err), .div_pulse(div_pulse), .tick(pre_tick), .wrap(wrap),
  .act_a(act_a), .act_b(act_b), .act_hi(act_hi)
);

// File: tb/sim_swallow_divider.sv
`timescale 1ns/1ps
module sim_swallow_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cfg_a = '0;
  logic [5:0] cfg_b = '0;
  logic       cfg_hi = 1'b0;
  logic       cfg_load = 1'b0;
  logic       div_pulse;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;
  int cur_a = 0, cur_b = 3, cur_hi = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  swallow_divider u0 (
    .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_hi(cfg_hi),
    .cfg_load(cfg_load), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  function automatic int period(int a, int b, int hi);
    return (hi != 0 ? 64 : 32) * b + a;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts negedges until the pulse is seen; start = cycles already spent
  task automatic measure(int start, string wtag, output int n);
    n = start;
    do begin
      @(negedge clk);
      n++;
      if (start == 0 && n == 1) check(wtag, int'(div_pulse), 0);
    end while (!div_pulse && n < 9000);
  endtask

  task automatic run_cfg(int a, int b, int hi, string ptag);
    int n;
    bit ok;
    ok = (b >= 3) && (b >= a);
    cfg_a = 6'(a); cfg_b = 6'(b); cfg_hi = hi[0]; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(ok ? "R8 err after legal load" :
          (b < 3 ? "R6 err after short B" : "R7 err after B<A"),
          int'(cfg_err), ok ? 0 : 1);
    measure(1, "R4", n);
    check("R9 period in progress keeps old length", n, period(cur_a, cur_b, cur_hi));
    if (ok) begin cur_a = a; cur_b = b; cur_hi = hi; end
    measure(0, "R4 pulse one cycle wide", n);
    check(ptag, n, period(cur_a, cur_b, cur_hi));
    check("R8 err unchanged without load", int'(cfg_err), ok ? 0 : 1);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check("R1 pulse low in reset", int'(div_pulse), 0);
    check("R1 err low in reset", int'(cfg_err), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pulse low after reset", int'(div_pulse), 0);
    check("R1 err low after reset", int'(cfg_err), 0);
    measure(1, "R4", n);
    check("R1 first period 96", n, 96);
    measure(0, "R4 pulse one cycle wide", n);
    check("R1 default period", n, 96);

    run_cfg(0, 3, 0, "R5 A=0 P=32");
    run_cfg(3, 3, 0, "R5 A=B P=32");
    run_cfg(2, 5, 0, "R2 P=32");
    run_cfg(17, 40, 0, "R2 P=32 mid");
    run_cfg(2, 2, 0, "R6 setting kept after short B");
    run_cfg(63, 63, 0, "R5 B=A=63 P=32");
    run_cfg(0, 63, 0, "R5 A=0 B=63 P=32");
    run_cfg(6, 5, 1, "R7 setting kept after B<A");
    run_cfg(0, 3, 1, "R5 A=0 P=64");
    run_cfg(3, 3, 1, "R5 A=B P=64");
    run_cfg(7, 10, 1, "R3 P=64");
    run_cfg(0, 0, 1, "R6 setting kept after B=0");
    run_cfg(1, 9, 1, "R3 P=64 swallow one");
    run_cfg(63, 63, 1, "R5 B=A=63 P=64");
    run_cfg(40, 39, 0, "R7 setting kept after B<A large");
    run_cfg(5, 31, 0, "R2 back to P=32");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #900us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule